// File: doc/BRIEF.md
# Global Trigger and Timestamp Unit

This block merges three kinds of trigger request into a single global trigger that strikes every acquisition channel in the same clock cycle. A request can come from a one-cycle software strobe, from the rising edge of an asynchronous external trigger line, or from the channels themselves. Each channel compares its incoming sample against its own programmable threshold. A per-channel polarity bit decides whether a sample counts as past threshold when it is above the threshold or when it is below it. A majority stage counts the enabled channels that are past threshold, and the self-trigger path fires when that count reaches a programmable level.

Each source has its own enable bit. A veto input blocks every source while it is high. After each global trigger, a programmable hold-off keeps new triggers out. The global trigger is mirrored on a trigger-out line so that other boards can follow it. A free-running coarse time counter advances once every `TICK_DIV` sample clocks. Its value is latched on every global trigger and returned as the event timestamp.

Top module: `gtrig_unit`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `gtrig`, `trig_out`, `ch_trig`, `maj_count` and `ts_latched` are all zero.
- R2: Channel i is past threshold when `under_mode[i]`=0 and sample > threshold, or when `under_mode[i]`=1 and sample < threshold. A sample equal to the threshold is never past threshold. One clock edge after the samples are presented, `maj_count` equals the number of channels that are past threshold and have their `ch_enable` bit set.
- R3: With `src_enable[2]` set and `maj_level` nonzero, `gtrig` rises on the clock edge after `maj_count` >= `maj_level`, which is two edges after the samples are presented. A `maj_level` of zero never fires the self-trigger path.
- R4: With `src_enable[0]` set, a one-cycle `sw_trig` pulse gives a one-cycle `gtrig` on the next clock edge.
- R5: With `src_enable[1]` set, a 0-to-1 transition of `ext_trig_in` raises `gtrig` on the third clock edge after the change. Keeping the line high gives no further trigger, and a 1-to-0 transition gives none.
- R6: While `veto` is high, no source can raise `gtrig` on the following edge.
- R7: After a `gtrig` pulse, `gtrig` stays low for the next `holdoff_cycles` cycles. A request held continuously therefore gives a pulse every `holdoff_cycles`+1 cycles.
- R8: `trig_out` equals `gtrig` in every cycle, and all bits of `ch_trig` are high exactly in the cycles in which `gtrig` is high.
- R9: The time counter starts at zero at reset, advances by one every `TICK_DIV` clock edges, and wraps to zero after its maximum value. The first advance happens on the `TICK_DIV`-th edge after reset is released. On the edge n (counted from reset release) at which `gtrig` rises, `ts_latched` takes the value floor((n-1)/`TICK_DIV`) mod 2^`TS_W`, and it holds that value until the next trigger.
- R10: A source whose `src_enable` bit is clear (bit 0 software, bit 1 external, bit 2 self) never raises `gtrig`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_trig | input | 1 | Software trigger strobe, one cycle |
| ext_trig_in | input | 1 | Asynchronous external trigger line |
| veto | input | 1 | Blocks all trigger sources while high |
| src_enable | input | 3 | Source enables: bit 0 software, bit 1 external, bit 2 self |
| ch_enable | input | NCH | Channels that take part in the majority count |
| under_mode | input | NCH | Per-channel polarity, 1 = below threshold counts |
| samples | input | NCH x SW | Current sample of each channel |
| thresholds | input | NCH x SW | Threshold of each channel |
| maj_level | input | clog2(NCH+1) | Minimum channel count for a self-trigger |
| holdoff_cycles | input | HOLD_W | Blocking window after each trigger, in cycles |
| gtrig | output | 1 | Global trigger pulse |
| trig_out | output | 1 | Copy of the global trigger for other boards |
| ch_trig | output | NCH | Trigger delivered to each channel |
| maj_count | output | clog2(NCH+1) | Enabled channels currently past threshold |
| ts_latched | output | TS_W | Time counter captured at the last trigger |

## Verification
Each result is due a fixed number of edges after its stimulus. `maj_count` is due one edge after the samples are presented, a software pulse raises `gtrig` one edge later, the self-trigger path two edges later, and an external edge three edges later because of the synchronizer and the edge register. The bench drives every input just after a falling edge and samples 1 ns after the rising edge that should carry the result. It also samples on the edges just before and after that one where a late, early or repeated pulse would show. The expected timestamp comes from a count of edges since reset release in the bench. A small configuration (6-bit counter) makes the wrap appear within the run.

// File: rtl/gtu_pkg.sv
// Package: shared source indices for the global trigger unit.
// Assumes: the source-enable vector is ordered software, external, self.
package gtu_pkg;
    localparam int NSRC     = 3;
    localparam int SRC_SW   = 0;
    localparam int SRC_EXT  = 1;
    localparam int SRC_SELF = 2;
endpackage

// File: rtl/gtu_disc.sv
// Module: one channel discriminator. It registers whether the sample is
// strictly above (under=0) or strictly below (under=1) the threshold.
// Assumes: sample and threshold are unsigned codes of equal width.
module gtu_disc #(
    parameter int SW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] sample,
    input  logic [SW-1:0] thresh,
    input  logic          under,
    output logic          hit
);
    logic past;

    // Compare the sample with the threshold in the selected direction.
    always_comb begin
        past = under ? (sample < thresh) : (sample > thresh);
    end

    // Register the compare result, one cycle of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) hit <= 1'b0;
        else        hit <= past;
    end
endmodule

// File: rtl/gtu_edge_sync.sv
// Module: brings an asynchronous line into the clock domain through two
// flops and emits a one-cycle pulse on each 0-to-1 transition.
// Assumes: the line stays stable for at least two clock periods per level.
module gtu_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [2:0] sh;

    // Shift the line through the synchronizer and the edge-history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[1:0], async_in};
    end

    // Detect a rising edge on the synchronized level.
    always_comb begin
        rise = sh[1] & ~sh[2];
    end
endmodule

// File: rtl/gtu_timebase.sv
// Module: free-running coarse time counter that advances once every
// TICK_DIV clocks and wraps to zero at its maximum value.
// Assumes: TICK_DIV >= 1.
module gtu_timebase #(
    parameter int TS_W     = 31,
    parameter int TICK_DIV = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] ts_now
);
    localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [DW-1:0] DLAST = DW'(TICK_DIV - 1);

    logic [DW-1:0] div;
    logic          tick;

    // Flag the last clock of each tick period.
    always_comb begin
        tick = (div == DLAST);
    end

    // Run the prescaler, restarting it at the end of each period.
    always_ff @(posedge clk) begin
        if (!rst_n)    div <= '0;
        else if (tick) div <= '0;
        else           div <= div + 1'b1;
    end

    // Advance the time counter once per tick, wrapping naturally.
    always_ff @(posedge clk) begin
        if (!rst_n)    ts_now <= '0;
        else if (tick) ts_now <= ts_now + 1'b1;
    end
endmodule

// File: rtl/gtrig_unit.sv
// Module: global trigger and timestamp unit. It merges software, external
// edge and majority self-trigger requests, applies the veto and hold-off,
// drives the global trigger to every channel and to trigger-out, and
// latches the coarse time counter on each trigger.
// Assumes: sw_trig is synchronous to clk; ext_trig_in may be asynchronous.
module gtrig_unit #(
    parameter int NCH      = 8,
    parameter int SW       = 12,
    parameter int TS_W     = 31,
    parameter int TICK_DIV = 4,
    parameter int HOLD_W   = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sw_trig,
    input  logic                        ext_trig_in,
    input  logic                        veto,
    input  logic [2:0]                  src_enable,
    input  logic [NCH-1:0]              ch_enable,
    input  logic [NCH-1:0]              under_mode,
    input  logic [NCH-1:0][SW-1:0]      samples,
    input  logic [NCH-1:0][SW-1:0]      thresholds,
    input  logic [$clog2(NCH+1)-1:0]    maj_level,
    input  logic [HOLD_W-1:0]           holdoff_cycles,
    output logic                        gtrig,
    output logic                        trig_out,
    output logic [NCH-1:0]              ch_trig,
    output logic [$clog2(NCH+1)-1:0]    maj_count,
    output logic [TS_W-1:0]             ts_latched
);
    import gtu_pkg::*;

    localparam int CW = $clog2(NCH + 1);

    logic [NCH-1:0]    hit;
    logic [CW-1:0]     count;
    logic              ext_rise;
    logic [NSRC-1:0]   req;
    logic [HOLD_W-1:0] hold_cnt;
    logic              busy;
    logic              fire;
    logic [TS_W-1:0]   ts_now;

    // One discriminator per channel.
    for (genvar i = 0; i < NCH; i++) begin : g_disc
        gtu_disc #(.SW(SW)) u_disc (
            .clk    (clk),
            .rst_n  (rst_n),
            .sample (samples[i]),
            .thresh (thresholds[i]),
            .under  (under_mode[i]),
            .hit    (hit[i])
        );
    end

    gtu_edge_sync u_ext (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_trig_in),
        .rise     (ext_rise)
    );

    gtu_timebase #(.TS_W(TS_W), .TICK_DIV(TICK_DIV)) u_tb (
        .clk    (clk),
        .rst_n  (rst_n),
        .ts_now (ts_now)
    );

    // Count the enabled channels that are past threshold.
    always_comb begin
        count = '0;
        for (int i = 0; i < NCH; i++) begin
            count = count + CW'(hit[i] & ch_enable[i]);
        end
    end

    // Gather the enabled requests and decide whether to fire this cycle.
    always_comb begin
        req[SRC_SW]   = src_enable[SRC_SW]  & sw_trig;
        req[SRC_EXT]  = src_enable[SRC_EXT] & ext_rise;
        req[SRC_SELF] = src_enable[SRC_SELF] & (maj_level != '0) &
                        (count >= maj_level);
        busy          = (hold_cnt != '0);
        fire          = (|req) & ~veto & ~busy;
    end

    // Load the hold-off window on a trigger, then count it down.
    always_ff @(posedge clk) begin
        if (!rst_n)         hold_cnt <= '0;
        else if (fire)      hold_cnt <= holdoff_cycles;
        else if (busy)      hold_cnt <= hold_cnt - 1'b1;
    end

    // Register the global trigger and its copies to channels and trigger-out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gtrig    <= 1'b0;
            trig_out <= 1'b0;
            ch_trig  <= '0;
        end else begin
            gtrig    <= fire;
            trig_out <= fire;
            ch_trig  <= {NCH{fire}};
        end
    end

    // Capture the time counter in the cycle the trigger fires.
    always_ff @(posedge clk) begin
        if (!rst_n)    ts_latched <= '0;
        else if (fire) ts_latched <= ts_now;
    end

    assign maj_count = count;
endmodule

// File: rtl/gtu_checker.sv
// Module: property checker for gtrig_unit, attached through bind.
// Assumes: holdoff_cycles is not changed while a hold-off is running.
module gtu_checker #(
    parameter int NCH    = 8,
    parameter int TS_W   = 31,
    parameter int HOLD_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     veto,
    input logic                     gtrig,
    input logic                     trig_out,
    input logic [NCH-1:0]           ch_trig,
    input logic [NCH-1:0]           ch_enable,
    input logic [$clog2(NCH+1)-1:0] maj_count,
    input logic [TS_W-1:0]          ts_latched,
    input logic [HOLD_W-1:0]        holdoff_cycles
);
    logic              seen;
    logic [HOLD_W:0]   gap;
    logic [HOLD_W-1:0] hold_cap;

    // Measure the cycles since the last trigger, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen     <= 1'b0;
            gap      <= '0;
            hold_cap <= '0;
        end else if (gtrig) begin
            seen     <= 1'b1;
            gap      <= '0;
            hold_cap <= holdoff_cycles;
        end else if (gap != {(HOLD_W+1){1'b1}}) begin
            gap      <= gap + 1'b1;
        end
    end

    assert_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_out == gtrig) && (ch_trig == {NCH{gtrig}}));

    assert_veto_R6: assert property (@(posedge clk) disable iff (!rst_n)
        veto |=> !gtrig);

    assert_holdoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && gtrig) |-> (gap >= {1'b0, hold_cap}));

    assert_maj_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        32'(maj_count) <= $countones(ch_enable));

    assert_ts_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !gtrig |-> $stable(ts_latched));
endmodule

bind gtrig_unit gtu_checker #(.NCH(NCH), .TS_W(TS_W), .HOLD_W(HOLD_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .veto           (veto),
    .gtrig          (gtrig),
    .trig_out       (trig_out),
    .ch_trig        (ch_trig),
    .ch_enable      (ch_enable),
    .maj_count      (maj_count),
    .ts_latched     (ts_latched),
    .holdoff_cycles (holdoff_cycles)
);

// File: tb/gtrig_unit_tb.sv
// Bench: sweeps the majority count, polarity, each trigger source, veto,
// hold-off and timestamp of a small gtrig_unit configuration.
module gtrig_unit_tb;
    localparam int NCH = 8, SW = 12, TS_W = 6, TDIV = 4, HW = 4;
    localparam int CW = $clog2(NCH + 1);
    localparam logic [SW-1:0] THR = 12'd100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_trig = 1'b0, ext_trig_in = 1'b0, veto = 1'b0;
    logic [2:0] src_enable = '0;
    logic [NCH-1:0] ch_enable = '1, under_mode = '0;
    logic [NCH-1:0][SW-1:0] samples = '0, thresholds = '0;
    logic [CW-1:0] maj_level = '0;
    logic [HW-1:0] holdoff_cycles = '0;
    logic gtrig, trig_out;
    logic [NCH-1:0] ch_trig;
    logic [CW-1:0] maj_count;
    logic [TS_W-1:0] ts_latched;

    int errors = 0, checks = 0;
    int ecount = 0;

    always #4 clk = ~clk;

    // Count clock edges since reset release for the expected timestamp.
    always @(posedge clk) if (rst_n) ecount <= ecount + 1;

    gtrig_unit #(.NCH(NCH), .SW(SW), .TS_W(TS_W), .TICK_DIV(TDIV), .HOLD_W(HW)) u_dut (
        .clk(clk), .rst_n(rst_n), .sw_trig(sw_trig), .ext_trig_in(ext_trig_in),
        .veto(veto), .src_enable(src_enable), .ch_enable(ch_enable),
        .under_mode(under_mode), .samples(samples), .thresholds(thresholds),
        .maj_level(maj_level), .holdoff_cycles(holdoff_cycles), .gtrig(gtrig),
        .trig_out(trig_out), .ch_trig(ch_trig), .maj_count(maj_count),
        .ts_latched(ts_latched)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic edge1();
        @(posedge clk); #1;
    endtask

    function automatic int exp_ts();
        return ((ecount - 1) / TDIV) % (1 << TS_W);
    endfunction

    task automatic idle(input int n);
        @(negedge clk);
        sw_trig = 0; samples = '0; veto = 0; under_mode = '0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(200000 * 8);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < NCH; i++) thresholds[i] = THR;
        repeat (3) edge1();
        // R1: reset state
        chk("R1 gtrig", gtrig, 0); chk("R1 trig_out", trig_out, 0);
        chk("R1 ch_trig", ch_trig, 0); chk("R1 maj", maj_count, 0);
        chk("R1 ts", ts_latched, 0);
        @(negedge clk); rst_n = 1;
        edge1();
        chk("R1 gtrig after release", gtrig, 0);
        chk("R1 ts after release", ts_latched, 0);

        // R2: majority count over all hit patterns and several enable masks
        for (int mi = 0; mi < 4; mi++) begin
            logic [NCH-1:0] m;
            m = (mi == 0) ? 8'hFF : (mi == 1) ? 8'hA5 : (mi == 2) ? 8'h3C : 8'h00;
            for (int p = 0; p < 256; p++) begin
                @(negedge clk);
                ch_enable = m;
                for (int i = 0; i < NCH; i++) samples[i] = p[i] ? THR + 1 : THR;
                edge1();
                chk("R2 maj count", maj_count, $countones(p[NCH-1:0] & m));
            end
        end
        ch_enable = '1;

        // R2: polarity and equality at the threshold for every channel
        for (int ch = 0; ch < NCH; ch++) begin
            for (int md = 0; md < 2; md++) begin
                for (int d = -1; d <= 1; d++) begin
                    @(negedge clk);
                    samples = '0; under_mode = '0;
                    under_mode[ch] = md[0];
                    samples[ch] = SW'(int'(THR) + d);
                    edge1();
                    chk("R2 polarity", maj_count, (md == 1) ? (d < 0) : (d > 0));
                end
            end
        end
        idle(2);

        // R3: self trigger for every level and hit count
        src_enable = 3'b100;
        for (int lv = 0; lv <= NCH; lv++) begin
            for (int k = 0; k <= NCH; k++) begin
                @(negedge clk);
                maj_level = CW'(lv);
                for (int i = 0; i < NCH; i++) samples[i] = (i < k) ? THR + 1 : 0;
                edge1();
                edge1();
                chk("R3 self fire", gtrig, (lv != 0) && (k >= lv));
                if (gtrig) chk("R9 ts at self trigger", ts_latched, exp_ts());
                idle(2);
            end
        end

        // R4, R8, R9: software pulses at varied phases
        src_enable = 3'b001;
        for (int g = 0; g < 12; g++) begin
            @(negedge clk); sw_trig = 1;
            edge1();
            chk("R4 sw fire", gtrig, 1);
            chk("R8 trig_out", trig_out, 1);
            chk("R8 ch_trig", ch_trig, 8'hFF);
            chk("R9 ts at sw trigger", ts_latched, exp_ts());
            @(negedge clk); sw_trig = 0;
            edge1();
            chk("R4 single pulse", gtrig, 0);
            chk("R8 trig_out low", trig_out, 0);
            repeat (g * 7) @(negedge clk);
        end

        // R5: external rising edge, held high, then falling edge
        src_enable = 3'b010;
        @(negedge clk); ext_trig_in = 1;
        edge1(); chk("R5 ext edge1", gtrig, 0);
        edge1(); chk("R5 ext edge2", gtrig, 0);
        edge1(); chk("R5 ext edge3", gtrig, 1);
        for (int j = 0; j < 5; j++) begin edge1(); chk("R5 ext held", gtrig, 0); end
        @(negedge clk); ext_trig_in = 0;
        for (int j = 0; j < 6; j++) begin edge1(); chk("R5 ext fall", gtrig, 0); end

        // R6: veto blocks all sources
        src_enable = 3'b111; maj_level = 1;
        @(negedge clk); veto = 1; sw_trig = 1; samples[0] = THR + 1; ext_trig_in = 1;
        for (int j = 0; j < 6; j++) begin edge1(); chk("R6 veto", gtrig, 0); end
        @(negedge clk); veto = 0; sw_trig = 0;
        edge1(); chk("R6 release", gtrig, 1);
        ext_trig_in = 0;
        idle(4);

        // R7: hold-off with a continuous request
        src_enable = 3'b001;
        for (int hi = 0; hi < 3; hi++) begin
            int h;
            h = (hi == 0) ? 0 : (hi == 1) ? 2 : 5;
            @(negedge clk); holdoff_cycles = HW'(h); sw_trig = 1;
            edge1(); chk("R7 first", gtrig, 1);
            for (int j = 1; j <= 3 * (h + 1); j++) begin
                edge1();
                chk("R7 holdoff", gtrig, (j % (h + 1)) == 0);
            end
            idle(16);
        end
        holdoff_cycles = 0;

        // R10: disabled sources are ignored
        src_enable = 3'b110;
        @(negedge clk); sw_trig = 1;
        edge1(); chk("R10 sw off", gtrig, 0);
        @(negedge clk); sw_trig = 0;
        src_enable = 3'b101;
        @(negedge clk); ext_trig_in = 1;
        for (int j = 0; j < 5; j++) begin edge1(); chk("R10 ext off", gtrig, 0); end
        ext_trig_in = 0;
        src_enable = 3'b011; maj_level = 1;
        @(negedge clk); samples[3] = THR + 1;
        for (int j = 0; j < 4; j++) begin edge1(); chk("R10 self off", gtrig, 0); end
        idle(2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule